// File: doc/BRIEF.md
# Orientation Histogram Peak Selector

This block collects a weighted orientation histogram for one keypoint neighbourhood and then reports its dominant directions. A start pulse wipes all 32 bins, each covering 11.25 degrees of the full circle. The block then accepts a stream of samples. Each sample carries a bin index and a weight, which is a gradient magnitude already scaled by a Gaussian circular window whose sigma is 1.5 times the keypoint scale. The sample flagged as last closes the neighbourhood.

Once the last sample is in, the block makes two sequential passes over the bins. The first pass finds the largest bin. The second pass emits, in ascending bin order and one per cycle, every non-zero bin whose value reaches 80% of that largest value. The test is made without division, as 5·value ≥ 4·max. One keypoint can therefore give several orientations at the same location and scale. A one-cycle done pulse closes every run.

Top module: `orient_peak_selector`

## Requirements
- R1: After reset, peakValid and done are both low, and they stay low until a run is started and closed.
- R2: A start pulse accepted while idle or accumulating sets all 32 bins to zero. While accumulating, each valid sample adds its weight to the bin named by sampleBin (a 5-bit index, 0 to 31).
- R3: A bin accumulator holds 16 bits and saturates at 65535 instead of wrapping.
- R4: After the last sample, each non-zero bin that satisfies 5·value ≥ 4·max is reported once. It is shown with peakValid high, its index on peakBin and its accumulated value on peakValue. Reports come in ascending index order, and no other bin is reported.
- R5: The largest bin is always reported, and when several bins tie at the maximum, every one of them is reported.
- R6: A bin at exactly 4/5 of the maximum is reported. A bin one step below that is not.
- R7: done is high for exactly one cycle per run and is never high in the same cycle as peakValid.
- R8: If every bin is zero when the last sample arrives, no bin is reported and only done is raised.
- R9: A valid sample presented in the same cycle as an accepted start is added to the freshly cleared histogram, so its bin holds exactly that sample's weight.
- R10: Samples and start pulses presented during the scan or the reporting pass are ignored and change neither the reported values nor the sequence.
- R11: Let the clock edge that accepts the last sample be edge 0. Bin b is reported in the cycle after edge 32+b, and done is high in the cycle after edge 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the histogram and opens a new neighbourhood |
| sampleValid | input | 1 | A sample is present on sampleBin and sampleWeight |
| sampleBin | input | 5 | Orientation bin index of the sample |
| sampleWeight | input | 12 | Window-scaled gradient magnitude of the sample |
| sampleLast | input | 1 | Marks the final sample of the neighbourhood |
| peakValid | output | 1 | A qualifying bin is being reported this cycle |
| peakBin | output | 5 | Index of the reported bin |
| peakValue | output | 16 | Accumulated value of the reported bin |
| done | output | 1 | One-cycle pulse after the reporting pass |

## Verification
Clearing and accumulation can occur in the same cycle. A start that arrives together with a valid sample must wipe all bins and still count that one sample. The bench provokes this after a run that has left other bins populated. It presents start and a sample for bin 4 in one cycle, then checks that only bin 4 is reported, with exactly the weight of that sample. A second overlap is a new start or sample arriving while the passes run. This is provoked in the middle of both the scan and the reporting pass, and judged by comparing the reported values with those of an undisturbed run.

// File: rtl/ohps_pkg.sv
package ohps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_SCAN,
    ST_EMIT,
    ST_DONE
  } phase_t;

  // strobes from the sequencer to the histogram datapath
  typedef struct packed {
    logic clr;      // wipe every bin
    logic acc;      // add the incoming sample
    logic maxInit;  // reset the running maximum
    logic maxUpd;   // fold the selected bin into the maximum
    logic emit;     // reporting pass active
  } strobe_t;

endpackage

// File: rtl/ohps_ctrl.sv
module ohps_ctrl
  import ohps_pkg::*;
#(
  parameter int NUM_BINS = 32,
  localparam int IDX_W = $clog2(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             sampleValid,
  input  logic             sampleLast,
  output strobe_t          strobes,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

  phase_t phase, phaseNext;
  logic   startOk;
  logic   lastHit;

  always_comb begin
    startOk = start && (phase == ST_IDLE || phase == ST_ACCUM);
    lastHit = sampleValid && sampleLast && (phase == ST_ACCUM) && !startOk;
    strobes.clr     = startOk;
    strobes.acc     = sampleValid && (startOk || phase == ST_ACCUM);
    strobes.maxInit = lastHit;
    strobes.maxUpd  = (phase == ST_SCAN);
    strobes.emit    = (phase == ST_EMIT);
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      ST_IDLE:  if (startOk) phaseNext = ST_ACCUM;
      ST_ACCUM: if (startOk) phaseNext = ST_ACCUM;
                else if (lastHit) phaseNext = ST_SCAN;
      ST_SCAN:  if (idx == LAST_IDX) phaseNext = ST_EMIT;
      ST_EMIT:  if (idx == LAST_IDX) phaseNext = ST_DONE;
      ST_DONE:  phaseNext = ST_IDLE;
      default:  phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      idx   <= '0;
    end else begin
      phase <= phaseNext;
      if (lastHit) begin
        idx <= '0;
      end else if (phase == ST_SCAN || phase == ST_EMIT) begin
        idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end
    end
  end

  assign done = (phase == ST_DONE);

endmodule

// File: rtl/ohps_datapath.sv
module ohps_datapath
  import ohps_pkg::*;
#(
  parameter int NUM_BINS = 32,
  parameter int WEIGHT_W = 12,
  parameter int ACC_W    = 16,
  localparam int IDX_W   = $clog2(NUM_BINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [IDX_W-1:0]    idx,
  input  logic [IDX_W-1:0]    sampleBin,
  input  logic [WEIGHT_W-1:0] sampleWeight,
  output logic                peakValid,
  output logic [IDX_W-1:0]    peakBin,
  output logic [ACC_W-1:0]    peakValue
);

  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  logic [ACC_W-1:0] hist [NUM_BINS];
  logic [ACC_W-1:0] maxReg;
  logic [ACC_W-1:0] selVal;
  logic [ACC_W+2:0] fiveSel;
  logic [ACC_W+2:0] fourMax;
  logic             qualify;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic             hit;
    logic [ACC_W:0]   sum;
    assign hit = strobes.acc && (sampleBin == IDX_W'(b));
    assign sum = {1'b0, hist[b]} + (ACC_W + 1)'(sampleWeight);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hist[b] <= '0;
      end else if (strobes.clr) begin
        hist[b] <= hit ? ACC_W'(sampleWeight) : '0;
      end else if (hit) begin
        hist[b] <= sum[ACC_W] ? FULL : sum[ACC_W-1:0];
      end
    end
  end

  assign selVal = hist[idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxReg <= '0;
    end else if (strobes.maxInit) begin
      maxReg <= '0;
    end else if (strobes.maxUpd && selVal > maxReg) begin
      maxReg <= selVal;
    end
  end

  // 80 % test without division: 5*value >= 4*max
  assign fiveSel = ({3'b000, selVal} << 2) + {3'b000, selVal};
  assign fourMax = {1'b0, maxReg, 2'b00};
  assign qualify = (selVal != '0) && (fiveSel >= fourMax);

  assign peakValid = strobes.emit && qualify;
  assign peakBin   = idx;
  assign peakValue = selVal;

endmodule

// File: rtl/orient_peak_selector.sv
module orient_peak_selector
  import ohps_pkg::*;
#(
  parameter int NUM_BINS = 32,
  parameter int WEIGHT_W = 12,
  parameter int ACC_W    = 16,
  localparam int IDX_W   = $clog2(NUM_BINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                sampleValid,
  input  logic [IDX_W-1:0]    sampleBin,
  input  logic [WEIGHT_W-1:0] sampleWeight,
  input  logic                sampleLast,
  output logic                peakValid,
  output logic [IDX_W-1:0]    peakBin,
  output logic [ACC_W-1:0]    peakValue,
  output logic                done
);

  strobe_t          strobes;
  logic [IDX_W-1:0] idx;

  ohps_ctrl #(.NUM_BINS(NUM_BINS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sampleValid(sampleValid),
    .sampleLast (sampleLast),
    .strobes    (strobes),
    .idx        (idx),
    .done       (done)
  );

  ohps_datapath #(
    .NUM_BINS(NUM_BINS),
    .WEIGHT_W(WEIGHT_W),
    .ACC_W   (ACC_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .idx         (idx),
    .sampleBin   (sampleBin),
    .sampleWeight(sampleWeight),
    .peakValid   (peakValid),
    .peakBin     (peakBin),
    .peakValue   (peakValue)
  );

endmodule

// File: rtl/ohps_checker.sv
module ohps_checker #(
  parameter int IDX_W = 5,
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             peakValid,
  input logic [IDX_W-1:0] peakBin,
  input logic [ACC_W-1:0] peakValue,
  input logic             done
);

  logic             haveLast;
  logic [IDX_W-1:0] lastBin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastBin  <= '0;
    end else if (done) begin
      haveLast <= 1'b0;
    end else if (peakValid) begin
      haveLast <= 1'b1;
      lastBin  <= peakBin;
    end
  end

  p_ascending_r4: assert property (@(posedge clk) disable iff (!rstN)
    (peakValid && haveLast) |-> (peakBin > lastBin));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(peakValid && done));

  p_nonzero_report_r8: assert property (@(posedge clk) disable iff (!rstN)
    peakValid |-> (peakValue != '0));

endmodule

bind orient_peak_selector ohps_checker #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .peakValid(peakValid),
  .peakBin  (peakBin),
  .peakValue(peakValue),
  .done     (done)
);

// File: tb/tb_orient_peak_selector.sv
`timescale 1ns/1ps
module tb_orient_peak_selector;

  localparam int VEC_N = 6;
  localparam int FULL  = 65535;

  localparam int vBin [VEC_N][4] = '{
    '{3, 3, 10, 20},
    '{5, 9, 9, 31},
    '{0, 1, 2, 3},
    '{7, 7, 7, 7},
    '{12, 13, 12, 13},
    '{31, 0, 16, 16}
  };
  localparam int vWgt [VEC_N][4] = '{
    '{100, 100, 150, 50},
    '{500, 300, 100, 400},
    '{1000, 799, 800, 1000},
    '{10, 10, 10, 10},
    '{4095, 4095, 1, 0},
    '{1, 2, 3, 0}
  };
  localparam logic [31:0] vMask [VEC_N] = '{
    32'h0000_0008,
    32'h8000_0220,
    32'h0000_000D,
    32'h0000_0080,
    32'h0000_3000,
    32'h0001_0000
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        sampleValid = 1'b0;
  logic [4:0]  sampleBin = '0;
  logic [11:0] sampleWeight = '0;
  logic        sampleLast = 1'b0;
  logic        peakValid;
  logic [4:0]  peakBin;
  logic [15:0] peakValue;
  logic        done;

  int total = 0;
  int bad = 0;
  int model [32];

  always #2 clk = ~clk;

  orient_peak_selector dut (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .sampleValid (sampleValid),
    .sampleBin   (sampleBin),
    .sampleWeight(sampleWeight),
    .sampleLast  (sampleLast),
    .peakValid   (peakValid),
    .peakBin     (peakBin),
    .peakValue   (peakValue),
    .done        (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit st, input bit v, input int b, input int w, input bit l);
    @(negedge clk);
    start        = st;
    sampleValid  = v;
    sampleBin    = 5'(b);
    sampleWeight = 12'(w);
    sampleLast   = l;
  endtask

  task automatic clearModel();
    for (int i = 0; i < 32; i++) model[i] = 0;
  endtask

  task automatic addModel(input int b, input int w);
    model[b] = (model[b] + w > FULL) ? FULL : model[b] + w;
  endtask

  // called right after the last sample was driven; k counts edges after it
  task automatic collect(input logic [31:0] expMask, input string req, input int injectAt);
    logic [31:0] gotMask;
    bit seenDone;
    gotMask  = '0;
    seenDone = 1'b0;
    for (int k = 1; k <= 66; k++) begin
      @(negedge clk);
      if (peakValid) begin
        gotMask[peakBin] = 1'b1;
        check(peakValue == 16'(model[peakBin]), req, "reported value",
              peakValue, model[peakBin]);
        check(k == 33 + int'(peakBin), "R11", "report cycle", k, 33 + int'(peakBin));
      end
      if (done) begin
        seenDone = 1'b1;
        check(k == 65, "R11", "done cycle", k, 65);
        check(!peakValid, "R7", "done with peakValid", peakValid, 0);
      end
      if (k == 66) check(!done, "R7", "done width", done, 0);
      if (k == injectAt) begin
        start = 1'b1; sampleValid = 1'b1; sampleBin = 5'd31;
        sampleWeight = 12'd4095; sampleLast = 1'b1;
      end else begin
        start = 1'b0; sampleValid = 1'b0; sampleBin = '0;
        sampleWeight = '0; sampleLast = 1'b0;
      end
    end
    check(seenDone, "R7", "done seen", seenDone, 1);
    check(gotMask == expMask, req, "reported bin mask", gotMask, expMask);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!peakValid, "R1", "peakValid after reset", peakValid, 0);
    check(!done, "R1", "done after reset", done, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!peakValid && !done, "R1", "outputs idle", {peakValid, done}, 0);

    // vector table: R4 general, V2 covers R5 ties and R6 boundary
    for (int v = 0; v < VEC_N; v++) begin
      clearModel();
      drive(1, 0, 0, 0, 0);
      for (int s = 0; s < 4; s++) begin
        addModel(vBin[v][s], vWgt[v][s]);
        drive(0, 1, vBin[v][s], vWgt[v][s], s == 3);
      end
      collect(vMask[v], (v == 2) ? "R5/R6" : "R4", 0);
    end

    // R3 saturation: 20 * 4095 exceeds 65535
    clearModel();
    drive(1, 0, 0, 0, 0);
    for (int s = 0; s < 20; s++) begin
      addModel(3, 4095);
      drive(0, 1, 3, 4095, s == 19);
    end
    check(model[3] == FULL, "R3", "model saturates", model[3], FULL);
    collect(32'h0000_0008, "R3", 0);

    // R9 / R2: start with sample in the same cycle after a populated run
    clearModel();
    addModel(4, 7);
    drive(1, 1, 4, 7, 0);
    drive(0, 1, 4, 0, 1);
    collect(32'h0000_0010, "R9", 0);

    // R8: all bins zero
    clearModel();
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 9, 0, 1);
    collect(32'h0, "R8", 0);

    // R10: disturbance during reporting pass
    clearModel();
    drive(1, 0, 0, 0, 0);
    addModel(20, 100);
    drive(0, 1, 20, 100, 0);
    addModel(31, 90);
    drive(0, 1, 31, 90, 1);
    collect(32'h8010_0000, "R10", 40);

    // R10: disturbance during scan pass
    clearModel();
    drive(1, 0, 0, 0, 0);
    addModel(0, 50);
    drive(0, 1, 0, 50, 0);
    addModel(31, 45);
    drive(0, 1, 31, 45, 1);
    collect(32'h8000_0001, "R10", 10);

    // R2: accumulation across many samples into one bin after a fresh start
    clearModel();
    drive(1, 0, 0, 0, 0);
    for (int s = 0; s < 8; s++) begin
      addModel(s % 2 == 0 ? 6 : 25, 30 + s);
      drive(0, 1, s % 2 == 0 ? 6 : 25, 30 + s, s == 7);
    end
    collect(32'h0200_0040, "R2", 0);

    repeat (2) @(negedge clk);
    check(!peakValid && !done, "R1", "idle after runs", {peakValid, done}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule